// File: doc/BRIEF.md
# USB PHY Suspend Wake Controller

This block controls the low-power state of a USB OTG transceiver. Software sets a PHY clock-disable bit, and the block then asserts the transceiver suspend output, which stops the clocks the transceiver derives. While suspended, the block tells the system that the bus clock may be gated or slowed. When the suspend is a full suspend, it also reports after a short hold that the high-speed PLL may be turned off.

While suspended, the block watches wake sources, and the set of sources depends on whether the controller runs as host or as device. Asynchronous transceiver signals pass through two-flop synchronizers, and edges are found by comparing each synchronized value with its value one cycle earlier. Once a wake event is latched, the block leaves suspend on the next clock. It does not suspend again until software clears the clock-disable bit and then sets it again.

Top module: `usb_phy_lpm`

## Requirements
- R1: While reset is asserted and after it is released, `phy_susp_o` is 0, `bus_clk_req_o` is 1 and `pll_off_ok_o` is 0.
- R2: When `clk_dis_i` is 1 in the active state, `phy_susp_o` rises at the next clock edge. `bus_clk_req_o` is low exactly while `phy_susp_o` is high.
- R3: If `clk_dis_i` is 0 while the block is suspended, `phy_susp_o` falls at the next clock edge.
- R4: In host mode (`host_mode_i`=1), these events wake the block: a rising edge of `dev_conn_i` when `wk_conn_en_i` is 1, a falling edge of `dev_conn_i` when `wk_disc_en_i` is 1, and a rising edge of `over_cur_i` when `wk_oc_en_i` is 1. With the enable at 0, the event has no effect.
- R5: In host mode, `rmt_wake_i` high wakes the block only while `bus_susp_i` is 1.
- R6: In device mode (`host_mode_i`=0), any change on `line_state_i` wakes the block (bit 0 is D+, bit 1 is D-). Line changes have no effect in host mode, and the host-only events of R4 have no effect in device mode.
- R7: Any edge on `vbus_valid_i` or `bsess_valid_i` wakes the block in either mode.
- R8: `host_wake_ni` low wakes the block only in host mode. `dev_wake_ni` low wakes it only in device mode.
- R9: After an asynchronous wake input changes, `phy_susp_o` stays high through two clock edges and falls at the third.
- R10: After a wake with `clk_dis_i` still 1, `phy_susp_o` stays low. It rises again only after `clk_dis_i` has been 0 and is then 1 once more.
- R11: `pll_off_ok_o` rises at the third clock edge after suspend entry, once `phy_susp_o` has been high for two cycles. In host mode this happens only if `otg_full_i` is 1; device mode does not depend on `otg_full_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_mode_i | input | 1 | 1 = host mode, 0 = device mode |
| clk_dis_i | input | 1 | Software PHY clock-disable bit |
| otg_full_i | input | 1 | Full-suspend permission for host mode, 0 after reset |
| wk_conn_en_i | input | 1 | Host wake-on-connect enable |
| wk_disc_en_i | input | 1 | Host wake-on-disconnect enable |
| wk_oc_en_i | input | 1 | Host wake-on-over-current enable |
| bus_susp_i | input | 1 | USB bus is in suspend (synchronous) |
| dev_conn_i | input | 1 | Device attached status (async) |
| over_cur_i | input | 1 | Over-current flag (async) |
| rmt_wake_i | input | 1 | Remote wake-up seen from attached device (async) |
| line_state_i | input | 2 | D+ (bit 0) and D- (bit 1) line state (async) |
| vbus_valid_i | input | 1 | VBUS-valid comparator (async) |
| bsess_valid_i | input | 1 | B-session-valid comparator (async) |
| host_wake_ni | input | 1 | External host-mode wake, active low (async) |
| dev_wake_ni | input | 1 | External device-mode wake, active low (async) |
| phy_susp_o | output | 1 | Transceiver suspend |
| bus_clk_req_o | output | 1 | Bus clock needed |
| pll_off_ok_o | output | 1 | High-speed PLL may be turned off |

## Verification
On every cycle, the assertions check four relations: the bus-clock request is always the complement of suspend, suspend never rises unless clock-disable was set, clearing the bit ends suspend in one clock, and the PLL-off indication only appears once suspend has held and never in host mode without full-suspend permission. Only the bench scenarios can show the rest: which wake source counts in which mode under which enable, the three-edge wake latency through the synchronizers, and the rule that suspend is not re-entered until software toggles the bit.

// File: rtl/usb_lpm_pkg.sv
package usb_lpm_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SUSP   = 2'd1,
    ST_HOLD   = 2'd2
  } lpm_state_e;

  // monitored transceiver inputs, bit positions in the sync bank
  localparam int unsigned MON_CONN  = 0;
  localparam int unsigned MON_OC    = 1;
  localparam int unsigned MON_RMT   = 2;
  localparam int unsigned MON_DP    = 3;
  localparam int unsigned MON_DM    = 4;
  localparam int unsigned MON_VBUS  = 5;
  localparam int unsigned MON_BSESS = 6;
  localparam int unsigned MON_NUM   = 7;

  // active-low external wake inputs
  localparam int unsigned XW_HOST = 0;
  localparam int unsigned XW_DEV  = 1;
  localparam int unsigned XW_NUM  = 2;
endpackage

// File: rtl/usb_lpm_sync.sv
module usb_lpm_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= RST;
    else         pipe_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= RST;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST;
    else         prev_q <= pipe_q[STAGES-1];
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~prev_q;
  assign fall_o = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/usb_lpm_wake_sel.sv
module usb_lpm_wake_sel
  import usb_lpm_pkg::*;
(
  input  logic               host_mode_i,
  input  logic               conn_en_i,
  input  logic               disc_en_i,
  input  logic               oc_en_i,
  input  logic               bus_susp_i,
  input  logic [MON_NUM-1:0] lvl_i,
  input  logic [MON_NUM-1:0] rise_i,
  input  logic [MON_NUM-1:0] fall_i,
  input  logic [XW_NUM-1:0]  xw_n_i,
  output logic               wake_o
);
  logic [MON_NUM-1:0] chg;
  logic host_hit, dev_hit, any_hit;

  assign chg = rise_i | fall_i;

  always_comb begin
    host_hit = (rise_i[MON_CONN] & conn_en_i)
             | (fall_i[MON_CONN] & disc_en_i)
             | (rise_i[MON_OC]   & oc_en_i)
             | (lvl_i[MON_RMT]   & bus_susp_i)
             | ~xw_n_i[XW_HOST];
    dev_hit  = chg[MON_DP] | chg[MON_DM] | ~xw_n_i[XW_DEV];
    any_hit  = chg[MON_VBUS] | chg[MON_BSESS];
    wake_o   = any_hit | (host_mode_i ? host_hit : dev_hit);
  end
endmodule

// File: rtl/usb_lpm_ctrl.sv
module usb_lpm_ctrl
  import usb_lpm_pkg::*;
#(
  parameter int unsigned PLL_HOLD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_dis_i,
  input  logic wake_i,
  input  logic host_mode_i,
  input  logic otg_full_i,
  output logic susp_o,
  output logic bus_clk_req_o,
  output logic pll_off_ok_o
);
  localparam int unsigned CNT_W = $clog2(PLL_HOLD + 1);

  lpm_state_e state_q, state_d;
  logic [CNT_W-1:0] hold_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: if (clk_dis_i) state_d = ST_SUSP;
      ST_SUSP: begin
        if (!clk_dis_i)  state_d = ST_ACTIVE;
        else if (wake_i) state_d = ST_HOLD;
      end
      ST_HOLD:   if (!clk_dis_i) state_d = ST_ACTIVE;
      default:   state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  // cycles spent in suspend, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hold_q <= '0;
    else if (state_q != ST_SUSP)         hold_q <= '0;
    else if (hold_q != CNT_W'(PLL_HOLD)) hold_q <= hold_q + 1'b1;
  end

  assign susp_o        = (state_q == ST_SUSP);
  assign bus_clk_req_o = (state_q != ST_SUSP);
  assign pll_off_ok_o  = susp_o && (hold_q == CNT_W'(PLL_HOLD))
                         && (!host_mode_i || otg_full_i);
endmodule

// File: rtl/usb_phy_lpm.sv
module usb_phy_lpm
  import usb_lpm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PLL_HOLD    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_mode_i,
  input  logic       clk_dis_i,
  input  logic       otg_full_i,
  input  logic       wk_conn_en_i,
  input  logic       wk_disc_en_i,
  input  logic       wk_oc_en_i,
  input  logic       bus_susp_i,
  input  logic       dev_conn_i,
  input  logic       over_cur_i,
  input  logic       rmt_wake_i,
  input  logic [1:0] line_state_i,
  input  logic       vbus_valid_i,
  input  logic       bsess_valid_i,
  input  logic       host_wake_ni,
  input  logic       dev_wake_ni,
  output logic       phy_susp_o,
  output logic       bus_clk_req_o,
  output logic       pll_off_ok_o
);
  logic [MON_NUM-1:0] mon_raw, mon_lvl, mon_rise, mon_fall;
  logic [XW_NUM-1:0]  xw_raw, xw_lvl, xw_rise, xw_fall;
  logic               wake;

  always_comb begin
    mon_raw            = '0;
    mon_raw[MON_CONN]  = dev_conn_i;
    mon_raw[MON_OC]    = over_cur_i;
    mon_raw[MON_RMT]   = rmt_wake_i;
    mon_raw[MON_DP]    = line_state_i[0];
    mon_raw[MON_DM]    = line_state_i[1];
    mon_raw[MON_VBUS]  = vbus_valid_i;
    mon_raw[MON_BSESS] = bsess_valid_i;
    xw_raw             = '1;
    xw_raw[XW_HOST]    = host_wake_ni;
    xw_raw[XW_DEV]     = dev_wake_ni;
  end

  usb_lpm_sync #(.W(MON_NUM), .STAGES(SYNC_STAGES), .RST('0)) u_mon_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(mon_raw),
    .lvl_o(mon_lvl), .rise_o(mon_rise), .fall_o(mon_fall)
  );

  usb_lpm_sync #(.W(XW_NUM), .STAGES(SYNC_STAGES), .RST('1)) u_xw_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(xw_raw),
    .lvl_o(xw_lvl), .rise_o(xw_rise), .fall_o(xw_fall)
  );

  usb_lpm_wake_sel u_wake_sel (
    .host_mode_i(host_mode_i), .conn_en_i(wk_conn_en_i),
    .disc_en_i(wk_disc_en_i), .oc_en_i(wk_oc_en_i), .bus_susp_i(bus_susp_i),
    .lvl_i(mon_lvl), .rise_i(mon_rise), .fall_i(mon_fall),
    .xw_n_i(xw_lvl), .wake_o(wake)
  );

  usb_lpm_ctrl #(.PLL_HOLD(PLL_HOLD)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_dis_i(clk_dis_i), .wake_i(wake),
    .host_mode_i(host_mode_i), .otg_full_i(otg_full_i),
    .susp_o(phy_susp_o), .bus_clk_req_o(bus_clk_req_o),
    .pll_off_ok_o(pll_off_ok_o)
  );
endmodule

// File: rtl/usb_phy_lpm_chk.sv
module usb_phy_lpm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic host_mode_i,
  input logic clk_dis_i,
  input logic otg_full_i,
  input logic phy_susp_o,
  input logic bus_clk_req_o,
  input logic pll_off_ok_o
);
  // R2
  bus_clk_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_clk_req_o == !phy_susp_o);

  // R2
  entry_needs_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_susp_o) |-> $past(clk_dis_i));

  // R3
  clear_exits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_susp_o && !clk_dis_i) |=> !phy_susp_o);

  // R11
  pll_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_off_ok_o |-> (phy_susp_o && $past(phy_susp_o)));

  // R11
  pll_host_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && !otg_full_i) |-> !pll_off_ok_o);
endmodule

bind usb_phy_lpm usb_phy_lpm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_mode_i(host_mode_i),
  .clk_dis_i(clk_dis_i), .otg_full_i(otg_full_i), .phy_susp_o(phy_susp_o),
  .bus_clk_req_o(bus_clk_req_o), .pll_off_ok_o(pll_off_ok_o)
);

// File: tb/usb_phy_lpm_bench.sv
module usb_phy_lpm_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, host_mode, clk_dis, otg_full, ce, de, oe, bus_susp;
  logic dev_conn, over_cur, rmt, vbus, bsess, hwn, dwn;
  logic [1:0] line;
  logic susp, bus_clk, pll;

  int errs = 0;
  int checks = 0;

  usb_phy_lpm u_usb_phy_lpm (
    .clk_i(clk), .rst_ni(rst_n), .host_mode_i(host_mode), .clk_dis_i(clk_dis),
    .otg_full_i(otg_full), .wk_conn_en_i(ce), .wk_disc_en_i(de),
    .wk_oc_en_i(oe), .bus_susp_i(bus_susp), .dev_conn_i(dev_conn),
    .over_cur_i(over_cur), .rmt_wake_i(rmt), .line_state_i(line),
    .vbus_valid_i(vbus), .bsess_valid_i(bsess), .host_wake_ni(hwn),
    .dev_wake_ni(dwn), .phy_susp_o(susp), .bus_clk_req_o(bus_clk),
    .pll_off_ok_o(pll)
  );

  // [10]host [9]otg [8]conn_en [7]disc_en [6]oc_en [5:2]stim [1]exp_wake [0]exp_pll
  localparam int NV = 17;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1,1'b1,3'b100,4'd1, 1'b1,1'b1},
    {1'b1,1'b0,3'b000,4'd1, 1'b0,1'b0},
    {1'b1,1'b1,3'b010,4'd2, 1'b1,1'b1},
    {1'b1,1'b1,3'b000,4'd2, 1'b0,1'b1},
    {1'b1,1'b0,3'b001,4'd3, 1'b1,1'b0},
    {1'b1,1'b0,3'b110,4'd3, 1'b0,1'b0},
    {1'b1,1'b0,3'b000,4'd4, 1'b1,1'b0},
    {1'b0,1'b0,3'b000,4'd5, 1'b1,1'b1},
    {1'b1,1'b1,3'b111,4'd5, 1'b0,1'b1},
    {1'b0,1'b0,3'b111,4'd1, 1'b0,1'b1},
    {1'b1,1'b1,3'b000,4'd6, 1'b1,1'b1},
    {1'b0,1'b1,3'b000,4'd7, 1'b1,1'b1},
    {1'b1,1'b0,3'b000,4'd8, 1'b1,1'b0},
    {1'b0,1'b0,3'b000,4'd8, 1'b0,1'b1},
    {1'b0,1'b0,3'b000,4'd9, 1'b1,1'b1},
    {1'b1,1'b1,3'b000,4'd0, 1'b0,1'b1},
    {1'b1,1'b1,3'b000,4'd10,1'b0,1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag_of(input int s);
    case (s)
      1, 2, 3: return "R4 host event";
      4, 10:   return "R5 remote wake";
      5:       return "R6 line change";
      6, 7:    return "R7 vbus/bsess edge";
      8, 9:    return "R8 external wake";
      default: return "R2 no wake";
    endcase
  endfunction

  task automatic baseline(input int s);
    dev_conn = (s == 2); over_cur = 1'b0; rmt = 1'b0; bus_susp = 1'b0;
    line = 2'b01; vbus = 1'b0; bsess = 1'b0; hwn = 1'b1; dwn = 1'b1;
  endtask

  task automatic apply_stim(input int s);
    case (s)
      1:  dev_conn = 1'b1;
      2:  dev_conn = 1'b0;
      3:  over_cur = 1'b1;
      4:  begin bus_susp = 1'b1; rmt = 1'b1; end
      5:  line = 2'b10;
      6:  vbus = 1'b1;
      7:  bsess = 1'b1;
      8:  hwn = 1'b0;
      9:  dwn = 1'b0;
      10: rmt = 1'b1;
      default: ;
    endcase
  endtask

  initial begin
    #(8 * 150000);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_mode = 1'b1; clk_dis = 1'b0; otg_full = 1'b0;
    ce = 1'b0; de = 1'b0; oe = 1'b0;
    baseline(0);
    step(3);
    // R1 reset state
    chk("R1 susp in reset", susp, 1'b0);
    chk("R1 bus_clk in reset", bus_clk, 1'b1);
    chk("R1 pll in reset", pll, 1'b0);
    rst_n = 1'b1;
    step(3);
    chk("R1 susp after reset", susp, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      int s;
      v = VEC[i];
      s = int'(v[5:2]);
      baseline(s);
      host_mode = v[10]; otg_full = v[9];
      ce = v[8]; de = v[7]; oe = v[6];
      step(5);
      clk_dis = 1'b1;
      step(4);
      chk("R2 suspend entry", susp, 1'b1);
      chk("R2 bus clock released", bus_clk, 1'b0);
      chk("R11 pll-off per mode", pll, v[0]);
      apply_stim(s);
      step(4);
      chk(tag_of(s), susp, ~v[1]);
      clk_dis = 1'b0;
      step(2);
      chk("R3 clear leaves suspend", susp, 1'b0);
      baseline(s);
      step(5);
    end

    // R9 latency and R11 pll timing, device mode
    host_mode = 1'b0; otg_full = 1'b0; baseline(0); step(5);
    clk_dis = 1'b1;
    step(1);
    chk("R2 entry at first edge", susp, 1'b1);
    chk("R11 pll low after 1 edge", pll, 1'b0);
    step(1);
    chk("R11 pll low after 2 edges", pll, 1'b0);
    step(1);
    chk("R11 pll high after 3 edges", pll, 1'b1);
    vbus = 1'b1;
    step(2);
    chk("R9 still suspended after 2 edges", susp, 1'b1);
    step(1);
    chk("R9 woken at 3rd edge", susp, 1'b0);
    chk("R2 bus clock requested", bus_clk, 1'b1);
    // R10 no re-entry while bit stays set
    step(8);
    chk("R10 stays awake with bit held", susp, 1'b0);
    clk_dis = 1'b0;
    step(2);
    chk("R10 still awake after clear", susp, 1'b0);
    clk_dis = 1'b1;
    step(1);
    chk("R10 re-entry after set", susp, 1'b1);
    // R3 immediate exit
    clk_dis = 1'b0;
    step(1);
    chk("R3 exit in one edge", susp, 1'b0);

    // R1 reset while suspended
    clk_dis = 1'b1;
    step(3);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears suspend", susp, 1'b0);
    chk("R1 async reset clears pll", pll, 1'b0);
    step(2);
    rst_n = 1'b1;
    clk_dis = 1'b0;
    step(2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule